// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block is a bus master for external SRAM and memory-mapped peripherals. It drives a single 16-bit bus on which address and data take turns. Internal logic hands it one read or one write at a time through a ready/valid handshake. Each request carries an address, write data and a width flag. The block then runs a fixed sequence of bus phases. An address-latch strobe marks the phase in which address bits are on the bus. A read strobe or a write strobe marks the phase in which data moves. A one-cycle done pulse reports completion, together with the captured read data.

The width flag selects one of two modes:

- **Wide mode** addresses devices with up to 16 address bits and moves 16 data bits per transfer.
- **Narrow mode** reaches a 24-bit address space with 8-bit devices. The upper 16 address bits go out while the latch strobe is high. The low address byte then shares the bus with the data byte during the strobe phase.

Every transfer takes at least three cycles. There is always a quiet cycle between the end of one strobe and the next address phase, and a read releases the data lanes before its strobe rises.

Top module: `mbm_port`

## Requirements
- R1: After reset, `strb_rd`, `strb_wr` and `strb_ale` are low, `ad_oe` is 2'b00, `rsp_done` is low and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the address phase to the end of the gap. Request inputs that change while the port is busy have no effect on the transfer in progress, and they start no new transfer.
- R3: In wide mode (`req_wide`=1), the cycle after acceptance is the address phase. In it, `strb_ale` is high, `ad_out` equals `req_addr[15:0]` and `ad_oe` is 2'b11. Bits 23:16 of the address are ignored.
- R4: In narrow mode (`req_wide`=0), the address phase drives `ad_out` = `req_addr[23:8]` with `ad_oe` = 2'b11.
- R5: A wide write follows its address phase directly with one cycle of `strb_wr`. In that cycle, `ad_out` = `req_wdata` and `ad_oe` = 2'b11.
- R6: In the narrow strobe phase, `ad_out[15:8]` carries `req_addr[7:0]` and `ad_oe[1]` is high. On a write, `ad_out[7:0]` carries `req_wdata[7:0]` and `ad_oe` = 2'b11. On a read, `ad_oe` = 2'b10.
- R7: A read inserts one turnaround cycle after its address phase. In that cycle, no strobe is high and the data lanes are already released: `ad_oe[0]` = 0 in narrow mode, and `ad_oe` = 2'b00 in wide mode. The data lanes stay released while `strb_rd` is high.
- R8: A read captures `ad_in` on the last `strb_rd` cycle. `rsp_rdata` shows the captured value while `rsp_done` is high. In wide mode, `rsp_rdata` is the full 16 bits. In narrow mode, `rsp_rdata` is `{8'h00, ad_in[7:0]}`.
- R9: At most one of `strb_rd`, `strb_wr` and `strb_ale` is high in any cycle.
- R10: `rsp_done` is high for exactly one cycle: the cycle right after the last read or write strobe cycle.
- R11: The next address phase comes at least two cycles after the last strobe cycle of the previous transfer. At least three cycles separate one address phase from the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Port idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| req_addr | input | 24 | Transfer address |
| req_wdata | input | 16 | Write data (low byte used in 8-bit mode) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| ad_out | output | 16 | Value driven on the shared bus |
| ad_oe | output | 2 | Per-byte drive enable (bit 1 = ad_out[15:8]) |
| ad_in | input | 16 | Value sampled from the shared bus |
| strb_ale | output | 1 | Address latch strobe, active high |
| strb_rd | output | 1 | Read strobe, active high |
| strb_wr | output | 1 | Write strobe, active high |

## Verification
The bench runs reads and writes in both width modes. It uses alternating-bit, all-zero, all-one and walking address and data values. These patterns expose the cases where the upper and lower address halves are swapped or shifted in the address phase, and the case where the low address byte and the data byte land on the wrong lanes in narrow mode. In narrow reads, the modelled device drives a non-zero upper byte, so a missing zero-extension shows up in the returned data. Some transfers keep `req_valid` high with altered address and data while the port is busy. This checks that in-flight values are latched and that no extra address phase appears. Back-to-back requests probe the minimum spacing between transfers.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ALE  = 3'd1,
      PH_TURN = 3'd2,
      PH_STRB = 3'd3,
      PH_GAP  = 3'd4
   } phase_e;

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/mbm_seq.sv
module mbm_seq
   import mbm_pkg::*;
#(
   parameter int ALE_CYC  = 1,
   parameter int TURN_CYC = 1,
   parameter int STRB_CYC = 1,
   parameter int GAP_CYC  = 1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  logic   read_i,
   output phase_e phase_o,
   output logic   last_strb_o
);

   localparam int MAXL = max4(ALE_CYC, TURN_CYC, STRB_CYC, GAP_CYC);
   localparam int CW   = (MAXL < 2) ? 1 : $clog2(MAXL);

   phase_e          phase_q, phase_d;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   len_m1;

   always_comb begin
      phase_d = phase_q;
      len_m1  = '0;
      unique case (phase_q)
         PH_IDLE: if (start_i) phase_d = PH_ALE;
         PH_ALE: begin
            len_m1 = CW'(ALE_CYC - 1);
            if (cnt_q == len_m1) phase_d = read_i ? PH_TURN : PH_STRB;
         end
         PH_TURN: begin
            len_m1 = CW'(TURN_CYC - 1);
            if (cnt_q == len_m1) phase_d = PH_STRB;
         end
         PH_STRB: begin
            len_m1 = CW'(STRB_CYC - 1);
            if (cnt_q == len_m1) phase_d = PH_GAP;
         end
         PH_GAP: begin
            len_m1 = CW'(GAP_CYC - 1);
            if (cnt_q == len_m1) phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         if (phase_d != phase_q || phase_q == PH_IDLE) cnt_q <= '0;
         else                                          cnt_q <= cnt_q + 1'b1;
      end
   end

   assign phase_o     = phase_q;
   assign last_strb_o = (phase_q == PH_STRB) && (cnt_q == CW'(STRB_CYC - 1));

   // R2: leaving idle only ever enters the address phase
   p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |=> (phase_q == PH_IDLE || phase_q == PH_ALE));

   // R11: a strobe phase is always followed by the gap phase
   p_strb_to_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STRB && phase_d != PH_STRB) |=> (phase_q == PH_GAP));

endmodule

// File: rtl/mbm_lane.sv
module mbm_lane
   import mbm_pkg::*;
#(
   parameter int AD_W   = 16,
   parameter int ADDR_W = 24
) (
   input  phase_e              phase_i,
   input  logic                write_i,
   input  logic                wide_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [AD_W-1:0]     wdata_i,
   output logic [AD_W-1:0]     ad_out_o,
   output logic [1:0]          ad_oe_o,
   output logic                ale_o,
   output logic                rd_o,
   output logic                wr_o
);

   localparam int HB = AD_W / 2;

   logic addr_ph, data_ph;
   assign addr_ph = (phase_i == PH_ALE);
   assign data_ph = (phase_i == PH_TURN) || (phase_i == PH_STRB);

   // Per-byte drive enables: lane 1 carries the low address byte in narrow mode
   for (genvar b = 0; b < 2; b++) begin : g_lane
      if (b == 1) begin : g_hi
         assign ad_oe_o[b] = addr_ph || (data_ph && (write_i || !wide_i));
      end else begin : g_lo
         assign ad_oe_o[b] = addr_ph || (data_ph && write_i);
      end
   end

   always_comb begin
      ad_out_o = '0;
      if (addr_ph) begin
         ad_out_o = wide_i ? addr_i[AD_W-1:0] : addr_i[ADDR_W-1 -: AD_W];
      end else if (data_ph) begin
         ad_out_o = wide_i ? wdata_i : {addr_i[HB-1:0], wdata_i[HB-1:0]};
      end
   end

   assign ale_o = addr_ph;
   assign rd_o  = (phase_i == PH_STRB) && !write_i;
   assign wr_o  = (phase_i == PH_STRB) && write_i;

endmodule

// File: rtl/mbm_capture.sv
module mbm_capture #(
   parameter int AD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            last_strb_i,
   input  logic            write_i,
   input  logic            wide_i,
   input  logic [AD_W-1:0] ad_in_i,
   output logic            done_o,
   output logic [AD_W-1:0] rdata_o
);

   localparam int HB = AD_W / 2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o  <= 1'b0;
         rdata_o <= '0;
      end else begin
         done_o <= last_strb_i;
         if (last_strb_i && !write_i)
            rdata_o <= wide_i ? ad_in_i : {{HB{1'b0}}, ad_in_i[HB-1:0]};
      end
   end

   // R10: completion is a single-cycle pulse
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: rtl/mbm_port.sv
module mbm_port
   import mbm_pkg::*;
#(
   parameter int AD_W     = 16,
   parameter int ADDR_W   = 24,
   parameter int ALE_CYC  = 1,
   parameter int TURN_CYC = 1,
   parameter int STRB_CYC = 1,
   parameter int GAP_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_wide,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [AD_W-1:0]   req_wdata,
   output logic              rsp_done,
   output logic [AD_W-1:0]   rsp_rdata,
   output logic [AD_W-1:0]   ad_out,
   output logic [1:0]        ad_oe,
   input  logic [AD_W-1:0]   ad_in,
   output logic              strb_ale,
   output logic              strb_rd,
   output logic              strb_wr
);

   localparam int MIN_XFER = ALE_CYC + STRB_CYC + GAP_CYC;

   if (AD_W != 16) begin : g_bad_bus
      $error("mbm_port: AD_W must be 16");
   end
   if (ADDR_W != AD_W + AD_W / 2) begin : g_bad_addr
      $error("mbm_port: ADDR_W must be AD_W plus one byte");
   end
   if (ALE_CYC < 1 || TURN_CYC < 1 || STRB_CYC < 1 || GAP_CYC < 1) begin : g_bad_len
      $error("mbm_port: every phase needs at least one cycle");
   end
   if (MIN_XFER < 3) begin : g_bad_rate
      $error("mbm_port: a transfer must span at least three cycles");
   end

   phase_e            phase;
   logic              last_strb;
   logic              accept;
   logic              write_q, wide_q;
   logic [ADDR_W-1:0] addr_q;
   logic [AD_W-1:0]   wdata_q;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         wide_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         write_q <= req_write;
         wide_q  <= req_wide;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   mbm_seq #(
      .ALE_CYC (ALE_CYC),
      .TURN_CYC(TURN_CYC),
      .STRB_CYC(STRB_CYC),
      .GAP_CYC (GAP_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (accept),
      .read_i     (!write_q),
      .phase_o    (phase),
      .last_strb_o(last_strb)
   );

   mbm_lane #(
      .AD_W  (AD_W),
      .ADDR_W(ADDR_W)
   ) u_lane (
      .phase_i (phase),
      .write_i (write_q),
      .wide_i  (wide_q),
      .addr_i  (addr_q),
      .wdata_i (wdata_q),
      .ad_out_o(ad_out),
      .ad_oe_o (ad_oe),
      .ale_o   (strb_ale),
      .rd_o    (strb_rd),
      .wr_o    (strb_wr)
   );

   mbm_capture #(
      .AD_W(AD_W)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .last_strb_i(last_strb),
      .write_i    (write_q),
      .wide_i     (wide_q),
      .ad_in_i    (ad_in),
      .done_o     (rsp_done),
      .rdata_o    (rsp_rdata)
   );

   // R9: strobes never overlap
   p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({strb_rd, strb_wr, strb_ale}) <= 1);

   // R7: the data lane is released while the read strobe is high
   p_rd_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
      strb_rd |-> !ad_oe[0]);

   // R7: the cycle before the read strobe rises is a quiet turnaround cycle
   p_turn_before_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strb_rd) |-> $past(!ad_oe[0] && !strb_ale));

   // R2: no new request is taken while any strobe is high
   p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_rd || strb_wr || strb_ale) |-> !req_ready);

   // R11: the cycle after a data strobe ends carries no address phase
   p_gap_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strb_rd || strb_wr) |-> (!strb_ale && !req_ready));

   // R10: done follows the last strobe cycle directly
   p_done_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ($past(strb_rd || strb_wr) && !strb_rd && !strb_wr));

endmodule

// File: tb/sim_mbm_port.sv
module sim_mbm_port;

   typedef struct {
      bit          wr;
      bit          wide;
      logic [23:0] addr;
      logic [15:0] wd;
      logic [15:0] rd;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_wide = 1'b0;
   logic [23:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        rsp_done;
   logic [15:0] rsp_rdata;
   logic [15:0] ad_out;
   logic [1:0]  ad_oe;
   logic [15:0] ad_in = '0;
   logic        strb_ale, strb_rd, strb_wr;

   int n_chk = 0;
   int n_err = 0;
   int n_issued = 0;
   int n_done = 0;
   bit mon_en = 1'b0;
   item_t q[$];

   always #5 clk = ~clk;

   mbm_port u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_wide(req_wide),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .strb_ale(strb_ale), .strb_rd(strb_rd), .strb_wr(strb_wr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Monitor: compares bus activity against the front of the scoreboard queue
   int cyc = 0;
   int last_ale = -100;
   int last_strb = -100;
   bit prev_str = 1'b0;
   bit prev_any = 1'b0;
   logic [1:0] prev_oe = 2'b00;

   always @(negedge clk) begin
      if (mon_en) begin
         cyc++;
         chk($countones({strb_rd, strb_wr, strb_ale}) <= 1, "R9", "strobe overlap",
             {29'd0, strb_rd, strb_wr, strb_ale}, 32'd0);
         if (strb_ale || strb_rd || strb_wr)
            chk(!req_ready, "R2", "ready while busy", {31'd0, req_ready}, 32'd0);
         if (strb_ale) begin
            chk(q.size() > 0, "R2", "address phase without request", q.size(), 1);
            chk(cyc - last_strb >= 2, "R11", "strobe to next address gap",
                cyc - last_strb, 2);
            chk(cyc - last_ale >= 3, "R11", "address phase spacing", cyc - last_ale, 3);
            last_ale = cyc;
            if (q.size() > 0) begin
               if (q[0].wide)
                  chk(ad_out == q[0].addr[15:0], "R3", "wide address phase",
                      ad_out, q[0].addr[15:0]);
               else
                  chk(ad_out == q[0].addr[23:8], "R4", "narrow address phase",
                      ad_out, q[0].addr[23:8]);
               chk(ad_oe == 2'b11, q[0].wide ? "R3" : "R4", "address drive", ad_oe, 2'b11);
            end
         end
         if (strb_wr && q.size() > 0) begin
            if (q[0].wide)
               chk(ad_out == q[0].wd, "R5", "wide write data", ad_out, q[0].wd);
            else
               chk(ad_out == {q[0].addr[7:0], q[0].wd[7:0]}, "R6", "narrow write lanes",
                   ad_out, {q[0].addr[7:0], q[0].wd[7:0]});
            chk(ad_oe == 2'b11, q[0].wide ? "R5" : "R6", "write drive", ad_oe, 2'b11);
            chk(cyc - last_ale == 1, "R5", "write follows address", cyc - last_ale, 1);
         end
         if (strb_rd && q.size() > 0) begin
            chk(!prev_any, "R7", "turnaround cycle quiet", {31'd0, prev_any}, 0);
            chk(prev_oe == (q[0].wide ? 2'b00 : 2'b10), "R7", "lanes released early",
                prev_oe, q[0].wide ? 2'b00 : 2'b10);
            chk(ad_oe == (q[0].wide ? 2'b00 : 2'b10), "R6", "read drive",
                ad_oe, q[0].wide ? 2'b00 : 2'b10);
            if (!q[0].wide)
               chk(ad_out[15:8] == q[0].addr[7:0], "R6", "narrow read low address",
                   ad_out[15:8], q[0].addr[7:0]);
         end
         if (prev_str && !(strb_rd || strb_wr))
            chk(rsp_done, "R10", "done after strobe", {31'd0, rsp_done}, 1);
         if (rsp_done) begin
            chk(prev_str && !strb_rd && !strb_wr, "R10", "done placement",
                {31'd0, prev_str}, 1);
            if (q.size() > 0) begin
               if (!q[0].wr)
                  chk(rsp_rdata == (q[0].wide ? q[0].rd : {8'h00, q[0].rd[7:0]}), "R8",
                      "read data", rsp_rdata, q[0].wide ? q[0].rd : {8'h00, q[0].rd[7:0]});
               void'(q.pop_front());
               n_done++;
            end else begin
               chk(1'b0, "R10", "done without request", 1, 0);
            end
         end
         if (strb_rd || strb_wr) last_strb = cyc;
         prev_str = strb_rd || strb_wr;
         prev_any = strb_rd || strb_wr || strb_ale;
         prev_oe  = ad_oe;
      end
   end

   // Driver: push expected item, issue request, optionally disturb inputs while busy
   task automatic xfer(input bit wr, input bit wide, input logic [23:0] addr,
                       input logic [15:0] wd, input logic [15:0] rd, input bit disturb);
      item_t it;
      it.wr = wr; it.wide = wide; it.addr = addr; it.wd = wd; it.rd = rd;
      q.push_back(it);
      n_issued++;
      ad_in     = rd;
      req_write = wr;
      req_wide  = wide;
      req_addr  = addr;
      req_wdata = wd;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      if (disturb) begin
         req_addr  = ~addr;
         req_wdata = ~wd;
         req_wide  = ~wide;
         req_write = ~wr;
      end else begin
         req_valid = 1'b0;
      end
      while (!rsp_done) @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            // R1: reset state
            chk(!strb_ale && !strb_rd && !strb_wr, "R1", "strobes in reset",
                {29'd0, strb_ale, strb_rd, strb_wr}, 0);
            chk(ad_oe == 2'b00, "R1", "drive in reset", ad_oe, 2'b00);
            chk(!rsp_done, "R1", "done in reset", {31'd0, rsp_done}, 0);
            rst_n = 1'b1;
            @(negedge clk);
            chk(req_ready, "R1", "ready after reset", {31'd0, req_ready}, 1);
            mon_en = 1'b1;
            xfer(1'b1, 1'b1, 24'h5A_A5C3, 16'hA5C3, 16'h0000, 1'b0);
            xfer(1'b1, 1'b0, 24'hAB_CDEF, 16'h1277, 16'h0000, 1'b0);
            xfer(1'b0, 1'b1, 24'h00_1234, 16'h0000, 16'hBEEF, 1'b0);
            xfer(1'b0, 1'b0, 24'hFF_FFFF, 16'h0000, 16'hC35A, 1'b0);
            xfer(1'b1, 1'b1, 24'hFF_0000, 16'hFFFF, 16'h0000, 1'b1);
            xfer(1'b0, 1'b0, 24'h00_0000, 16'h0000, 16'h7E81, 1'b1);
            xfer(1'b1, 1'b0, 24'h81_4201, 16'h00FF, 16'h0000, 1'b1);
            xfer(1'b0, 1'b1, 24'h3C_8001, 16'h0000, 16'h0001, 1'b1);
            for (int i = 0; i < 16; i++) begin
               xfer(i[0], i[1], 24'h000001 << i, 16'h0001 << i, ~(16'h0001 << i), i[2]);
            end
            repeat (4) @(negedge clk);
            chk(q.size() == 0, "R2", "all requests completed", q.size(), 0);
            chk(n_done == n_issued, "R2", "one completion per request", n_done, n_issued);
         end
         begin
            repeat (5000) @(posedge clk);
            chk(1'b0, "R10", "watchdog expired", 0, 1);
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule